// File: doc/BRIEF.md
# Four-Channel Down-Counter Timer with Prioritized Interrupt Vector

This block sits on an 8-bit processor bus. It holds four independent down-counters. Each channel has a single write address. The byte written there is one of three things, depending on the channel's state and on bit 0 of the byte: a control word, an interrupt vector base, or a reload value.

Each channel counts in one of two ways. In timer mode it counts clock ticks divided by a prescaler of 16 or 256. In counter mode it counts edges seen on its own trigger pin. A timer can also be set to wait for a trigger edge before it starts. When a channel reaches zero, it reloads its reload value and pulses its zero-count output. If its interrupt is enabled, it also raises a request.

The requests from all four channels are ranked by fixed priority. The winning request is presented to the processor on an interrupt-acknowledge cycle as one vector byte. The block also takes part in a daisy chain through an enable-in and an enable-out line. A software routine reads any counter through a separate read select.

Top module: `cnt_timer_quad`

## Requirements
- R1: After reset, every counter reads 0, every channel is stopped, `zc` is 0, `int_n` is 1, `vec_oe` is 0 and `ieo` follows `iei`.
- R2: Bytes written to a channel are decoded as follows:
  - If the channel is expecting a reload value, the byte is that value, whatever its bit 0.
  - Otherwise, bit 0 = 1 makes it a control word.
  - Otherwise, bit 0 = 0 makes it the vector base, which is kept only when written to channel 0.
  - Control bit 2 = 1 marks the next byte as the reload value.
- R3: In timer mode (control bit 6 = 0), control bit 5 selects the prescaler: 0 divides by 16 and 1 divides by 256. A freshly loaded count first decrements 16 (or 256) clocks after the reload-value write.
- R4: When the count steps down from 1, the counter takes the reload value and `zc` of that channel is high for exactly one clock.
- R5: A reload value of 0 acts as 256: the counter reads 0, and one step later it reads 255.
- R6: In counter mode (control bit 6 = 1), the counter steps once per active trigger edge. Control bit 4 = 1 selects rising edges and 0 selects falling edges. The opposite edge has no effect. Through the two-stage input synchronizer, the count changes on the third clock edge after the pin change.
- R7: With control bit 3 = 1 in timer mode, a loaded timer holds its count until an active trigger edge. For prescaler 16, the first decrement lands 20 clock edges after the pin change.
- R8: Control bit 1 = 1 stops the channel. The count stays frozen and no `zc` pulse occurs until a new reload value is written.
- R9: Control bit 7 = 1 lets a zero count raise that channel's request. With bit 7 = 0, `int_n` and `ieo` are unaffected.
- R10: The vector byte is laid out as follows:
  - bits 7..3 come from the vector base;
  - bits 2..1 are the number of the lowest-numbered eligible channel (channel 0 has the highest priority);
  - bit 0 is 0.
  The vector stays steady while the acknowledge is held.
- R11: Daisy-chain behaviour:
  - `int_n` is low only while `iei` is high and an eligible request exists.
  - `vec_oe` is high only when both `m1_n` and `iorq_n` are low, `iei` is high, and a request is eligible or has just been acknowledged.
  - `ieo` is low while any request is pending or in service.
- R12: An acknowledge moves the chosen channel from pending to in service. While a channel is in service, lower-priority requests are held back. A one-clock `isr_done` with `iei` high ends the service of the highest-priority channel in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one clock |
| wsel | input | 2 | Channel addressed by a write |
| wdata | input | 8 | Write data byte |
| rsel | input | 2 | Channel whose count is read |
| rdata | output | 8 | Current count of channel `rsel` |
| trg | input | 4 | Trigger/count pins, one per channel |
| zc | output | 4 | One-clock zero-count pulses |
| m1_n | input | 1 | Active-low first-cycle strobe |
| iorq_n | input | 1 | Active-low I/O request; low with `m1_n` marks an acknowledge |
| iei | input | 1 | Daisy-chain enable in |
| isr_done | input | 1 | One-clock end-of-service pulse |
| int_n | output | 1 | Active-low interrupt request |
| ieo | output | 1 | Daisy-chain enable out |
| vec_oe | output | 1 | Vector byte valid on `vec` |
| vec | output | 8 | Interrupt vector byte |

## Verification
The properties assume the following about the inputs:
- `m1_n` and `iorq_n` fall together and stay low across at least one rising clock edge during an acknowledge.
- `isr_done` lasts a single clock.
- Trigger pins change no faster than the clock.

The stimulus drives every input at falling clock edges. It releases an acknowledge only after one full rising edge has captured it. It lets each pin level settle for several clocks before the next change, so every synchronized edge is seen exactly once.

// File: rtl/ctmr_pkg.sv
`timescale 1ns/1ps
package ctmr_pkg;
    localparam int unsigned NCH = 4;
    localparam int unsigned DW  = 8;

    // control-word bit positions (software-visible encoding)
    localparam int unsigned B_IE   = 7;
    localparam int unsigned B_CNT  = 6;
    localparam int unsigned B_DIV  = 5;
    localparam int unsigned B_RISE = 4;
    localparam int unsigned B_TRG  = 3;
    localparam int unsigned B_TCF  = 2;
    localparam int unsigned B_SRST = 1;
    localparam int unsigned B_CTL  = 0;

    typedef struct packed {
        logic ie;
        logic cnt_mode;
        logic div256;
        logic rise;
        logic wait_trg;
    } ch_cfg_t;
endpackage

// File: rtl/ctmr_chan.sv
`timescale 1ns/1ps
module ctmr_chan
    import ctmr_pkg::*;
#(
    parameter int unsigned DWID   = 8,
    parameter int unsigned PSC_LO = 16,
    parameter int unsigned PSC_HI = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [DWID-1:0] wdata,
    input  logic            trg_pin,
    output logic [DWID-1:0] count,
    output logic            zc,
    output logic            tc_wait,
    output logic            irq_set,
    output logic            irq_clr
);
    localparam int unsigned PW = $clog2(PSC_HI);

    typedef struct packed {
        ch_cfg_t         cfg;
        logic            tcw;
        logic [DWID-1:0] tc;
        logic [DWID-1:0] cnt;
        logic            run;
        logic            armed;
        logic            go;
        logic [PW-1:0]   psc;
        logic            s1;
        logic            s2;
        logic            prv;
        logic            zc;
    } ch_st_t;

    ch_st_t st_q, st_d;
    logic edge_seen, tick;
    logic [PW-1:0] psc_top;

    always_comb begin
        st_d = st_q;
        st_d.s1  = trg_pin;
        st_d.s2  = st_q.s1;
        st_d.prv = st_q.s2;
        st_d.zc  = 1'b0;
        edge_seen = st_q.cfg.rise ? (st_q.s2 & ~st_q.prv) : (~st_q.s2 & st_q.prv);
        psc_top   = st_q.cfg.div256 ? PW'(PSC_HI - 1) : PW'(PSC_LO - 1);
        tick      = 1'b0;

        if (st_q.run) begin
            if (st_q.cfg.cnt_mode) begin
                tick = edge_seen;
            end else if (st_q.psc == psc_top) begin
                st_d.psc = '0;
                tick     = 1'b1;
            end else begin
                st_d.psc = st_q.psc + 1'b1;
            end
        end

        // trigger start: edge seen -> go -> running
        if (st_q.go) begin
            st_d.go  = 1'b0;
            st_d.run = 1'b1;
        end
        if (st_q.armed && edge_seen) begin
            st_d.armed = 1'b0;
            st_d.go    = 1'b1;
        end

        if (tick) begin
            if (st_q.cnt == DWID'(1)) begin
                st_d.cnt = st_q.tc;
                st_d.zc  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (wr) begin
            if (st_q.tcw) begin
                st_d.tc  = wdata;
                st_d.tcw = 1'b0;
                if (!st_q.run && !st_q.armed && !st_q.go) begin
                    st_d.cnt = wdata;
                    st_d.psc = '0;
                    if (st_q.cfg.cnt_mode || !st_q.cfg.wait_trg) st_d.run   = 1'b1;
                    else                                          st_d.armed = 1'b1;
                end
            end else if (wdata[B_CTL]) begin
                st_d.cfg.ie       = wdata[B_IE];
                st_d.cfg.cnt_mode = wdata[B_CNT];
                st_d.cfg.div256   = wdata[B_DIV];
                st_d.cfg.rise     = wdata[B_RISE];
                st_d.cfg.wait_trg = wdata[B_TRG];
                st_d.tcw          = wdata[B_TCF];
                if (wdata[B_SRST]) begin
                    st_d.run   = 1'b0;
                    st_d.armed = 1'b0;
                    st_d.go    = 1'b0;
                    st_d.psc   = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign zc      = st_q.zc;
    assign tc_wait = st_q.tcw;
    assign irq_set = st_q.zc & st_q.cfg.ie;
    assign irq_clr = wr & ~st_q.tcw & wdata[B_CTL] & ~wdata[B_IE];
endmodule

// File: rtl/ctmr_irq.sv
`timescale 1ns/1ps
module ctmr_irq #(
    parameter int unsigned NCHAN = 4,
    parameter int unsigned DWID  = 8,
    localparam int unsigned CHW  = $clog2(NCHAN),
    localparam int unsigned VW   = DWID - CHW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCHAN-1:0] req_set,
    input  logic [NCHAN-1:0] req_clr,
    input  logic             iei,
    input  logic             m1_n,
    input  logic             iorq_n,
    input  logic             isr_done,
    input  logic [VW-1:0]    vbase,
    output logic             int_n,
    output logic             ieo,
    output logic             vec_oe,
    output logic [DWID-1:0]  vec
);
    typedef struct packed {
        logic [NCHAN-1:0] ip;
        logic [NCHAN-1:0] ius;
        logic             ack_q;
        logic             hold;
        logic [CHW-1:0]   ch;
    } irq_st_t;

    irq_st_t st_q, st_d;
    logic [NCHAN-1:0] elig;
    logic             any_elig, inta, seen, done_f;
    logic [CHW-1:0]   sel, vchan;

    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < NCHAN; i++) begin
            seen    = seen | st_q.ius[i];
            elig[i] = st_q.ip[i] & ~seen;
        end
        any_elig = |elig;
        sel = '0;
        for (int i = NCHAN - 1; i >= 0; i--) begin
            if (elig[i]) sel = CHW'(i);
        end
        inta = ~m1_n & ~iorq_n;

        st_d       = st_q;
        st_d.ack_q = inta;
        st_d.ip    = (st_q.ip | req_set) & ~req_clr;
        if (inta && !st_q.ack_q) begin
            st_d.hold = iei & any_elig;
            st_d.ch   = sel;
            if (iei && any_elig) begin
                st_d.ip[sel]  = 1'b0;
                st_d.ius[sel] = 1'b1;
            end
        end
        if (!inta) st_d.hold = 1'b0;

        done_f = 1'b0;
        if (isr_done && iei) begin
            for (int i = 0; i < NCHAN; i++) begin
                if (!done_f && st_q.ius[i]) begin
                    st_d.ius[i] = 1'b0;
                    done_f      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vchan  = st_q.ack_q ? st_q.ch : sel;
    assign vec    = {vbase, vchan, 1'b0};
    assign vec_oe = inta & iei & (st_q.ack_q ? st_q.hold : any_elig);
    assign int_n  = ~(iei & any_elig);
    assign ieo    = iei & ~(|st_q.ip) & ~(|st_q.ius);
endmodule

// File: rtl/cnt_timer_quad.sv
`timescale 1ns/1ps
module cnt_timer_quad
    import ctmr_pkg::*;
#(
    parameter int unsigned NCHAN  = NCH,
    parameter int unsigned DWID   = DW,
    parameter int unsigned PSC_LO = 16,
    parameter int unsigned PSC_HI = 256,
    localparam int unsigned CHW   = $clog2(NCHAN),
    localparam int unsigned VW    = DWID - CHW - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CHW-1:0]   wsel,
    input  logic [DWID-1:0]  wdata,
    input  logic [CHW-1:0]   rsel,
    output logic [DWID-1:0]  rdata,
    input  logic [NCHAN-1:0] trg,
    output logic [NCHAN-1:0] zc,
    input  logic             m1_n,
    input  logic             iorq_n,
    input  logic             iei,
    input  logic             isr_done,
    output logic             int_n,
    output logic             ieo,
    output logic             vec_oe,
    output logic [DWID-1:0]  vec
);
    logic [DWID-1:0]  cnt_a [NCHAN];
    logic [NCHAN-1:0] tcw, set_v, clr_v;
    logic [VW-1:0]    vbase_d, vbase_q;

    for (genvar g = 0; g < NCHAN; g++) begin : g_ch
        ctmr_chan #(.DWID(DWID), .PSC_LO(PSC_LO), .PSC_HI(PSC_HI)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (wr_en && (wsel == CHW'(g))),
            .wdata   (wdata),
            .trg_pin (trg[g]),
            .count   (cnt_a[g]),
            .zc      (zc[g]),
            .tc_wait (tcw[g]),
            .irq_set (set_v[g]),
            .irq_clr (clr_v[g])
        );
    end

    always_comb begin
        vbase_d = vbase_q;
        if (wr_en && wsel == '0 && !tcw[0] && !wdata[0]) vbase_d = wdata[DWID-1:CHW+1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vbase_q <= '0;
        else        vbase_q <= vbase_d;
    end

    assign rdata = cnt_a[rsel];

    ctmr_irq #(.NCHAN(NCHAN), .DWID(DWID)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_set  (set_v),
        .req_clr  (clr_v),
        .iei      (iei),
        .m1_n     (m1_n),
        .iorq_n   (iorq_n),
        .isr_done (isr_done),
        .vbase    (vbase_q),
        .int_n    (int_n),
        .ieo      (ieo),
        .vec_oe   (vec_oe),
        .vec      (vec)
    );
endmodule

// File: rtl/cnt_timer_quad_chk.sv
`timescale 1ns/1ps
module cnt_timer_quad_chk #(
    parameter int unsigned NCHAN = 4,
    parameter int unsigned DWID  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCHAN-1:0] zc,
    input logic             int_n,
    input logic             ieo,
    input logic             iei,
    input logic             m1_n,
    input logic             iorq_n,
    input logic             vec_oe,
    input logic [DWID-1:0]  vec
);
    a_r4_zc_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (zc & $past(zc)) == '0);

    a_r10_vec_low_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (vec[0] == 1'b0));

    a_r11_vec_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (!m1_n && !iorq_n && iei));

    a_r11_int_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> iei);

    a_r11_ieo_low_while_req: assert property (@(posedge clk) disable iff (!rst_n)
        !int_n |-> !ieo);

    a_r10_vec_steady_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && $past(vec_oe)) |-> $stable(vec));
endmodule

bind cnt_timer_quad cnt_timer_quad_chk #(.NCHAN(NCHAN), .DWID(DWID)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .zc     (zc),
    .int_n  (int_n),
    .ieo    (ieo),
    .iei    (iei),
    .m1_n   (m1_n),
    .iorq_n (iorq_n),
    .vec_oe (vec_oe),
    .vec    (vec)
);

// File: tb/sim_cnt_timer_quad.sv
`timescale 1ns/1ps
module sim_cnt_timer_quad;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wsel = '0;
    logic [7:0] wdata = '0;
    logic [1:0] rsel = '0;
    logic [7:0] rdata;
    logic [3:0] trg = '0;
    logic [3:0] zc;
    logic       m1_n = 1'b1;
    logic       iorq_n = 1'b1;
    logic       iei = 1'b1;
    logic       isr_done = 1'b0;
    logic       int_n, ieo, vec_oe;
    logic [7:0] vec;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;

    typedef struct { int ch; int at; } ev_t;
    ev_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cnt_timer_quad u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wsel(wsel), .wdata(wdata),
        .rsel(rsel), .rdata(rdata), .trg(trg), .zc(zc), .m1_n(m1_n),
        .iorq_n(iorq_n), .iei(iei), .isr_done(isr_done), .int_n(int_n),
        .ieo(ieo), .vec_oe(vec_oe), .vec(vec)
    );

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // monitor: pops expected zero-count events as the design produces them
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 4; c++) begin
                if (zc[c]) begin
                    if (exp_q.size() == 0) begin
                        check("R4/R8 unexpected zc channel", c, 99);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        check("R4 zc channel", c, e.ch);
                        check("R4 zc cycle", cyc, e.at);
                    end
                end
            end
        end
    end

    task automatic wr_byte(input int ch, input logic [7:0] b, output int w);
        @(negedge clk);
        wr_en = 1'b1; wsel = 2'(ch); wdata = b;
        @(negedge clk);
        wr_en = 1'b0;
        w = cyc;
    endtask

    task automatic peek(input int ch, output int v);
        rsel = 2'(ch);
        #1;
        v = int'(rdata);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic pin(input int ch, input logic lvl, output int c);
        @(negedge clk);
        trg[ch] = lvl;
        c = cyc;
    endtask

    task automatic expect_zc(input int ch, input int at);
        ev_t e;
        e.ch = ch; e.at = at;
        exp_q.push_back(e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual %0d expected done", cyc);
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int w, v, c, c2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 int_n", int_n, 1);
        check("R1 ieo", ieo, 1);
        check("R1 zc", zc, 0);
        check("R1 vec_oe", vec_oe, 0);
        for (int k = 0; k < 4; k++) begin
            peek(k, v);
            check("R1 count", v, 0);
        end

        // R3/R4 channel 1 timer, prescale 16, reload 3
        wr_byte(1, 8'h07, w);
        wr_byte(1, 8'h03, w);
        expect_zc(1, w + 48);
        wait_to(w + 15); peek(1, v); check("R3 before first tick", v, 3);
        wait_to(w + 16); peek(1, v); check("R3 first tick /16", v, 2);
        wait_to(w + 47); peek(1, v); check("R3 third period", v, 1);
        wait_to(w + 48); peek(1, v); check("R4 reload after zero", v, 3);
        // R8 software reset freezes
        wr_byte(1, 8'h03, w);
        peek(1, v); c = v;
        repeat (120) @(negedge clk);
        peek(1, v); check("R8 stopped count frozen", v, c);

        // R3 channel 2 prescale 256, reload 2
        wr_byte(2, 8'h27, w);
        wr_byte(2, 8'h02, w);
        expect_zc(2, w + 512);
        wait_to(w + 255); peek(2, v); check("R3 /256 before tick", v, 2);
        wait_to(w + 256); peek(2, v); check("R3 /256 first tick", v, 1);
        wait_to(w + 512); peek(2, v); check("R4 /256 reload", v, 2);
        wr_byte(2, 8'h03, w);

        // R5/R6 channel 3 counter, rising edge, reload 0 (=256)
        wr_byte(3, 8'h57, w);
        wr_byte(3, 8'h00, w);
        peek(3, v); check("R5 zero reload reads 0", v, 0);
        pin(3, 1'b1, c);
        wait_to(c + 3); peek(3, v); check("R5 0 steps to 255", v, 255);
        pin(3, 1'b0, c);
        wait_to(c + 4); peek(3, v); check("R6 falling edge ignored", v, 255);
        // switch to falling edges, reload 2
        wr_byte(3, 8'h47, w);
        wr_byte(3, 8'h02, w);
        pin(3, 1'b1, c);
        wait_to(c + 4); peek(3, v); check("R6 rising edge ignored", v, 2);
        pin(3, 1'b0, c);
        wait_to(c + 3); peek(3, v); check("R6 falling edge counts", v, 1);
        pin(3, 1'b1, c);
        wait_to(c + 4);
        pin(3, 1'b0, c2);
        expect_zc(3, c2 + 3);
        wait_to(c2 + 3); peek(3, v); check("R4 counter reload", v, 2);
        wr_byte(3, 8'h03, w);

        // R2 byte with bit0 set after reload flag is a reload value
        wr_byte(2, 8'h47, w);
        wr_byte(2, 8'h05, w);
        peek(2, v); check("R2 odd byte taken as reload", v, 5);
        wr_byte(2, 8'h03, w);

        // R7 triggered timer on channel 0
        wr_byte(0, 8'h1F, w);
        wr_byte(0, 8'h01, w);
        repeat (40) @(negedge clk);
        peek(0, v); check("R7 waits for trigger", v, 1);
        pin(0, 1'b1, c);
        expect_zc(0, c + 20);
        wait_to(c + 19); peek(0, v); check("R7 not yet counted", v, 1);
        wait_to(c + 20); peek(0, v); check("R7 reload after start", v, 1);
        wr_byte(0, 8'h03, w);

        // R2 vector base via channel 0; write to channel 2 ignored
        wr_byte(0, 8'hA8, w);
        wr_byte(2, 8'h50, w);

        // R9-R12 interrupts: ch1 and ch2 counter, rising, enabled, reload 1
        wr_byte(1, 8'hD7, w);
        wr_byte(1, 8'h01, w);
        wr_byte(2, 8'hD7, w);
        wr_byte(2, 8'h01, w);
        iei = 1'b0;
        @(negedge clk);
        trg[1] = 1'b1; trg[2] = 1'b1; c = cyc;
        expect_zc(1, c + 3);
        expect_zc(2, c + 3);
        wait_to(c + 5);
        check("R11 int_n held by iei low", int_n, 1);
        check("R11 ieo low with pending", ieo, 0);
        m1_n = 1'b0; iorq_n = 1'b0; #1;
        check("R11 no vector with iei low", vec_oe, 0);
        @(negedge clk);
        m1_n = 1'b1; iorq_n = 1'b1;
        iei = 1'b1; #1;
        check("R11 int_n with iei high", int_n, 0);
        check("R11 ieo low", ieo, 0);
        @(negedge clk);
        m1_n = 1'b0; iorq_n = 1'b0; #1;
        check("R11 vec_oe on ack", vec_oe, 1);
        check("R10 vector ch1 first", vec, 8'hAA);
        @(negedge clk);
        check("R10 vector held", vec, 8'hAA);
        m1_n = 1'b1; iorq_n = 1'b1;
        @(negedge clk);
        check("R12 lower held back", int_n, 1);
        isr_done = 1'b1;
        @(negedge clk);
        isr_done = 1'b0;
        check("R12 ch2 after service end", int_n, 0);
        m1_n = 1'b0; iorq_n = 1'b0; #1;
        check("R10 vector ch2", vec, 8'hAC);
        @(negedge clk);
        m1_n = 1'b1; iorq_n = 1'b1;
        isr_done = 1'b1;
        @(negedge clk);
        isr_done = 1'b0;
        @(negedge clk);
        check("R12 all done int_n", int_n, 1);
        check("R12 all done ieo", ieo, 1);

        // R9 disabled channel zero count raises nothing
        wr_byte(3, 8'h57, w);
        wr_byte(3, 8'h01, w);
        pin(3, 1'b1, c);
        expect_zc(3, c + 3);
        wait_to(c + 6);
        check("R9 int_n stays high", int_n, 1);
        check("R9 ieo stays high", ieo, 1);

        repeat (10) @(negedge clk);
        check("R4 all expected zc seen", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule